// File: doc/BRIEF.md
# Urgency-Driven Thread Switch Controller

This block decides when a core that holds two hardware thread contexts, but runs only one of them at a time, should hand the pipeline over to the other. Each context carries a small urgency score. Per-thread event pulses move the score up or down. The controller compares the score of the running thread with the score of the waiting thread. When the waiting thread is more urgent, or when software asks for a switch, the controller raises a flush request. It holds that request until the pipeline reports that it has drained, and only then flips the foreground select.

Fairness comes from a run-quantum timer. The timer counts the cycles the foreground thread spends running. When the quantum runs out, it pushes the waiting thread to the top urgency level. The timer restarts on every completed switch. A thread that has just taken over gives up any boost above the nominal level, so a thread that won by timeout or interrupt does not keep that advantage.

Top module: `tsw_ctrl`

## Requirements
- R1: After reset, `fg_id_o` is 0, `flush_req_o` is 0, and both urgency fields read the nominal level 5. Context 0's urgency is `urg_o[2:0]` and context 1's is `urg_o[5:3]`.
- R2: A miss pulse lowers that context's urgency by one on the next edge. At 0 it stays at 0 and does not wrap.
- R3: A data-return pulse sets that context's urgency to 5 on the next edge. If it arrives in the same cycle as a miss for that context, the data return wins.
- R4: An interrupt pulse sets that context's urgency to 6 on the next edge. It wins over a miss or data return for that context in the same cycle.
- R5: The quantum is TIMEOUT_CYC. After TIMEOUT_CYC consecutive edges with no flush pending, counted from reset or from the last completed switch, the background context's urgency becomes 7 on the TIMEOUT_CYC-th edge. The timer does not advance while a flush is pending.
- R6: When no flush is pending and the foreground urgency is strictly lower than the background urgency, `flush_req_o` rises on the next edge. Equal urgencies cause no switch.
- R7: A `hint_i` pulse seen at an edge while no flush is pending raises `flush_req_o` at that edge. A hint that arrives while a flush is pending is ignored.
- R8: While `flush_req_o` is high, `fg_id_o` holds. At the edge where `flush_done_i` is seen with the request high, `fg_id_o` toggles and `flush_req_o` falls. `flush_done_i` has no effect when no flush is pending.
- R9: At the edge that completes a switch, the incoming thread's urgency is lowered to 5 if it would otherwise be above 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_i | input | 2 | Per-context long-latency miss pulse |
| ret_i | input | 2 | Per-context miss data return pulse |
| irq_i | input | 2 | Per-context external interrupt pulse |
| hint_i | input | 1 | Software switch hint from the foreground thread |
| flush_done_i | input | 1 | Pipeline reports it has drained |
| flush_req_o | output | 1 | Request to drain the pipeline before a switch |
| fg_id_o | output | 1 | Foreground context select |
| urg_o | output | 2*URG_W | Packed urgency of both contexts |

## Verification
The bench drives a run of misses past zero. A design that wraps would show 7 and trigger a spurious switch back. It also drives misses, returns and interrupts into the same cycle, which catches a wrong order of precedence. The quantum is checked one edge before and one edge after expiry, and again after a switch, so an off-by-one or a missing reload shows up as a wrong edge. Hints and flush-done pulses are sent at times when they must be ignored. Equal urgencies must not switch, and an incoming thread that kept its boost would show 6 or 7 instead of 5.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int CTX = 2;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_FLUSH = 1'b1
  } sw_state_t;
endpackage

// File: rtl/tsw_urgency.sv
module tsw_urgency #(
  parameter int URG_W   = 3,
  parameter int NOMINAL = 5,
  parameter int IRQ_LVL = 6,
  parameter int TMO_LVL = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_i,
  input  logic             ret_i,
  input  logic             irq_i,
  input  logic             tmo_i,
  input  logic             cap_i,
  output logic [URG_W-1:0] urg_o
);
  localparam logic [URG_W-1:0] NOM_V = URG_W'(NOMINAL);
  localparam logic [URG_W-1:0] IRQ_V = URG_W'(IRQ_LVL);
  localparam logic [URG_W-1:0] TMO_V = URG_W'(TMO_LVL);

  logic [URG_W-1:0] nxt;

  // later assignments take precedence: timeout > interrupt > return > miss
  always_comb begin
    nxt = urg_o;
    if (miss_i && urg_o != '0) nxt = urg_o - 1'b1;
    if (ret_i)                 nxt = NOM_V;
    if (irq_i)                 nxt = IRQ_V;
    if (tmo_i)                 nxt = TMO_V;
    if (cap_i && nxt > NOM_V)  nxt = NOM_V;
  end

  always_ff @(posedge clk) begin
    if (rst) urg_o <= NOM_V;
    else     urg_o <= nxt;
  end
endmodule

// File: rtl/tsw_quantum_timer.sv
module tsw_quantum_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic reload_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] cnt;

  assign expire_o = run_i && !reload_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (reload_i)              cnt <= '0;
    else if (run_i && cnt != FULL)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsw_switch_fsm.sv
module tsw_switch_fsm
  import tsw_pkg::*;
#(
  parameter int URG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [URG_W-1:0] fg_urg_i,
  input  logic [URG_W-1:0] bg_urg_i,
  input  logic             hint_i,
  input  logic             flush_done_i,
  output logic             flush_req_o,
  output logic             fg_id_o,
  output logic             done_o,
  output logic             run_o
);
  sw_state_t state;

  assign flush_req_o = (state == ST_FLUSH);
  assign run_o       = (state == ST_RUN);
  assign done_o      = (state == ST_FLUSH) && flush_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      fg_id_o <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (hint_i || (fg_urg_i < bg_urg_i)) state <= ST_FLUSH;
        end
        default: begin
          if (flush_done_i) begin
            state   <= ST_RUN;
            fg_id_o <= ~fg_id_o;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int URG_W       = 3,
  parameter int NOMINAL     = 5,
  parameter int IRQ_LVL     = 6,
  parameter int TMO_LVL     = 7,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             miss_i,
  input  logic [1:0]             ret_i,
  input  logic [1:0]             irq_i,
  input  logic                   hint_i,
  input  logic                   flush_done_i,
  output logic                   flush_req_o,
  output logic                   fg_id_o,
  output logic [2*URG_W-1:0]     urg_o
);
  logic [URG_W-1:0] urg_q [CTX];
  logic [CTX-1:0]   tmo_set;
  logic [CTX-1:0]   cap;
  logic             expire;
  logic             done;
  logic             run;
  logic [URG_W-1:0] fg_urg;
  logic [URG_W-1:0] bg_urg;

  assign fg_urg = urg_q[fg_id_o];
  assign bg_urg = urg_q[~fg_id_o];

  for (genvar g = 0; g < CTX; g++) begin : g_ctx
    assign tmo_set[g] = expire && (fg_id_o != 1'(g));
    assign cap[g]     = done   && (fg_id_o != 1'(g));

    tsw_urgency #(
      .URG_W  (URG_W),
      .NOMINAL(NOMINAL),
      .IRQ_LVL(IRQ_LVL),
      .TMO_LVL(TMO_LVL)
    ) u_urg (
      .clk   (clk),
      .rst   (rst),
      .miss_i(miss_i[g]),
      .ret_i (ret_i[g]),
      .irq_i (irq_i[g]),
      .tmo_i (tmo_set[g]),
      .cap_i (cap[g]),
      .urg_o (urg_q[g])
    );

    assign urg_o[g*URG_W +: URG_W] = urg_q[g];
  end

  tsw_quantum_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .reload_i(done),
    .expire_o(expire)
  );

  tsw_switch_fsm #(
    .URG_W(URG_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .fg_urg_i    (fg_urg),
    .bg_urg_i    (bg_urg),
    .hint_i      (hint_i),
    .flush_done_i(flush_done_i),
    .flush_req_o (flush_req_o),
    .fg_id_o     (fg_id_o),
    .done_o      (done),
    .run_o       (run)
  );
endmodule

// File: rtl/tsw_ctrl_checker.sv
module tsw_ctrl_checker #(
  parameter int URG_W   = 3,
  parameter int NOMINAL = 5,
  parameter int IRQ_LVL = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         miss_i,
  input logic [1:0]         ret_i,
  input logic [1:0]         irq_i,
  input logic               hint_i,
  input logic               flush_done_i,
  input logic               flush_req_o,
  input logic               fg_id_o,
  input logic [2*URG_W-1:0] urg_o,
  input logic [1:0]         tmo_set,
  input logic [1:0]         cap
);
  logic [URG_W-1:0] u0, u1, fgu, bgu;
  logic             live;

  assign u0  = urg_o[URG_W-1:0];
  assign u1  = urg_o[2*URG_W-1:URG_W];
  assign fgu = fg_id_o ? u1 : u0;
  assign bgu = fg_id_o ? u0 : u1;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fg_id_o == 1'b0 && !flush_req_o &&
             u0 == URG_W'(NOMINAL) && u1 == URG_W'(NOMINAL)));

  assert_miss_floor_R2: assert property (@(posedge clk) disable iff (rst)
    live && miss_i[0] && !ret_i[0] && !irq_i[0] && !tmo_set[0] && u0 == '0
      |=> u0 == '0);

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (rst)
    live && irq_i[1] && !tmo_set[1] && !cap[1] |=> u1 == URG_W'(IRQ_LVL));

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (rst)
    live && $rose(flush_req_o) |-> $past(hint_i || (fgu < bgu)));

  assert_flush_hold_R8: assert property (@(posedge clk) disable iff (rst)
    live && flush_req_o && !flush_done_i |=> flush_req_o && $stable(fg_id_o));

  assert_fg_change_R8: assert property (@(posedge clk) disable iff (rst)
    live && (fg_id_o != $past(fg_id_o)) |-> $past(flush_req_o && flush_done_i));

  assert_incoming_cap_R9: assert property (@(posedge clk) disable iff (rst)
    live && cap[1] |=> u1 <= URG_W'(NOMINAL));
endmodule

bind tsw_ctrl tsw_ctrl_checker #(
  .URG_W  (URG_W),
  .NOMINAL(NOMINAL),
  .IRQ_LVL(IRQ_LVL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .miss_i      (miss_i),
  .ret_i       (ret_i),
  .irq_i       (irq_i),
  .hint_i      (hint_i),
  .flush_done_i(flush_done_i),
  .flush_req_o (flush_req_o),
  .fg_id_o     (fg_id_o),
  .urg_o       (urg_o),
  .tmo_set     (tmo_set),
  .cap         (cap)
);

// File: tb/tsw_ctrl_bench.sv
`timescale 1ns/1ps
module tsw_ctrl_bench;
  localparam int URG_W = 3;
  localparam int TMO   = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       miss_i = '0, ret_i = '0, irq_i = '0;
  logic             hint_i = 1'b0, flush_done_i = 1'b0;
  logic             flush_req_o, fg_id_o;
  logic [2*URG_W-1:0] urg_o;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  tsw_ctrl #(.URG_W(URG_W), .TIMEOUT_CYC(TMO)) u_tsw_ctrl (
    .clk(clk), .rst(rst), .miss_i(miss_i), .ret_i(ret_i), .irq_i(irq_i),
    .hint_i(hint_i), .flush_done_i(flush_done_i), .flush_req_o(flush_req_o),
    .fg_id_o(fg_id_o), .urg_o(urg_o)
  );

  function automatic int urg(input int k);
    return int'(urg_o[k*URG_W +: URG_W]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; miss_i = '0; ret_i = '0; irq_i = '0;
    hint_i = 1'b0; flush_done_i = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic ack();
    flush_done_i = 1'b1; step(); flush_done_i = 1'b0;
  endtask

  task automatic t_reset_and_ties();
    do_reset();
    chk("R1 fg", int'(fg_id_o), 0);
    chk("R1 flush", int'(flush_req_o), 0);
    chk("R1 urg0", urg(0), 5);
    chk("R1 urg1", urg(1), 5);
    repeat (3) step();
    chk("R6 equal 5 no switch", int'(flush_req_o), 0);
    irq_i = 2'b11; step(); irq_i = '0;
    chk("R4 irq urg0", urg(0), 6);
    chk("R4 irq urg1", urg(1), 6);
    step(); step();
    chk("R6 equal 6 no switch", int'(flush_req_o), 0);
  endtask

  task automatic t_miss_floor();
    do_reset();
    miss_i = 2'b01; step(); miss_i = '0;
    chk("R2 first miss", urg(0), 4);
    chk("R6 not yet", int'(flush_req_o), 0);
    step();
    chk("R6 lower fg switches", int'(flush_req_o), 1);
    miss_i = 2'b01;
    repeat (5) step();
    miss_i = '0;
    chk("R2 floor at 0", urg(0), 0);
    chk("R8 req held", int'(flush_req_o), 1);
    chk("R8 fg held", int'(fg_id_o), 0);
    ack();
    chk("R8 fg toggled", int'(fg_id_o), 1);
    chk("R8 req dropped", int'(flush_req_o), 0);
    chk("R9 incoming at 5", urg(1), 5);
    step(); step();
    chk("R6 no switch back", int'(flush_req_o), 0);
    ack();
    chk("R8 stray done ignored", int'(fg_id_o), 1);
    step();
    chk("R8 stray done no req", int'(flush_req_o), 0);
  endtask

  task automatic t_events();
    do_reset();
    miss_i = 2'b10; step(); step(); miss_i = '0;
    chk("R2 bg miss twice", urg(1), 3);
    chk("R6 bg lower no switch", int'(flush_req_o), 0);
    ret_i = 2'b10; step(); ret_i = '0;
    chk("R3 return to 5", urg(1), 5);
    miss_i = 2'b10; ret_i = 2'b10; step(); miss_i = '0; ret_i = '0;
    chk("R3 return beats miss", urg(1), 5);
    irq_i = 2'b10; ret_i = 2'b10; miss_i = 2'b10; step();
    irq_i = '0; ret_i = '0; miss_i = '0;
    chk("R4 irq beats others", urg(1), 6);
    step();
    chk("R6 irq bg switches", int'(flush_req_o), 1);
    ack();
    chk("R8 fg now 1", int'(fg_id_o), 1);
    chk("R9 boost dropped", urg(1), 5);
    chk("R9 outgoing kept", urg(0), 5);
  endtask

  task automatic t_quantum();
    do_reset();
    repeat (TMO - 1) step();
    chk("R5 before expiry", urg(1), 5);
    step();
    chk("R5 expiry sets 7", urg(1), 7);
    chk("R5 req not yet", int'(flush_req_o), 0);
    step();
    chk("R5 req after expiry", int'(flush_req_o), 1);
    repeat (4) step();
    chk("R5 frozen in flush", urg(0), 5);
    ack();
    chk("R9 winner capped", urg(1), 5);
    chk("R5 fg switched", int'(fg_id_o), 1);
    repeat (TMO - 1) step();
    chk("R5 reload before", urg(0), 5);
    step();
    chk("R5 reload expiry", urg(0), 7);
    step();
    chk("R5 second switch req", int'(flush_req_o), 1);
  endtask

  task automatic t_hint();
    do_reset();
    hint_i = 1'b1; step(); hint_i = 1'b0;
    chk("R7 hint raises req", int'(flush_req_o), 1);
    hint_i = 1'b1; step(); hint_i = 1'b0;
    chk("R7 fg held", int'(fg_id_o), 0);
    ack();
    chk("R7 switched", int'(fg_id_o), 1);
    step(); step();
    chk("R7 pending hint ignored", int'(flush_req_o), 0);
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    t_reset_and_ties();
    t_miss_floor();
    t_events();
    t_quantum();
    t_hint();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule